// File: doc/BRIEF.md
# Hardware Page Pool Manager

This block hands out and takes back fixed-size memory pages for a set of client cores, with no processor involved. The pages that are free are held as a chain: an internal next-pointer memory gives each page's successor, and the manager keeps only the head page, the tail page and the number of free pages. After reset every page is free and chained in ascending order.

A client that needs storage asks for pages one at a time; the page at the head of the chain goes to it in the cycle of the grant. A client that has finished with a whole chain of pages returns it in one request that gives the first page, the last page and the length. The manager joins that chain behind its tail by writing one next pointer. A single link port lets clients set the successor of a page they hold, so that they can build the chain they later return. One allocation and one release are granted in every cycle, each chosen round-robin among the clients that ask. The free count and an empty flag are outputs.

Top module: `page_pool_mgr`

## Requirements
- R1: After reset the free count equals the number of pages, the empty flag is low, and repeated allocations return pages 0, 1, 2 and so on in ascending order.
- R2: In a cycle where the pool is not empty and at least one client asks, exactly one requesting client sees its allocate grant bit high, the page output gives that client's page (the current head of the free chain), and the page then leaves the pool.
- R3: A granted release joins the returned chain behind all pages already free: the returned pages are later allocated in chain order, from the given first page through its links to the given last page.
- R4: After each cycle the free count equals its old value, minus one if an allocation was granted, plus the returned length if a release was granted; both may happen in the same cycle.
- R5: When the free count is zero the empty flag is high and no allocate grant bit is set, however many clients ask; a release into an empty pool makes the returned chain the whole free chain.
- R6: When exactly one page is free and an allocation and a release are granted in the same cycle, the single page goes to the allocating client and the next allocations return the returned chain in order.
- R7: Allocate grants rotate: after client k is granted, the search for the next grant starts at client k+1 (wrapping), so the requesting client nearest after k wins; the first search after reset starts at client 0.
- R8: Release grants rotate among requesting clients by the same rule as R7, with their own position independent of the allocate one.
- R9: A link write, with the link-enable input high for one cycle, sets the successor of the given page to the given page index; a later release relies on those links.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| alloc_req | input | NUM_CLIENTS | One allocate request bit per client |
| alloc_gnt | output | NUM_CLIENTS | One-hot allocate grant; a page is taken at the clock edge |
| alloc_page | output | IW | Page index given with the allocate grant |
| rel_req | input | NUM_CLIENTS | One release request bit per client |
| rel_head | input | NUM_CLIENTS*IW | First page of each client's returned chain, client 0 in the low bits |
| rel_tail | input | NUM_CLIENTS*IW | Last page of each client's returned chain |
| rel_len | input | NUM_CLIENTS*CW | Page count of each client's returned chain |
| rel_gnt | output | NUM_CLIENTS | One-hot release grant; the chain is joined at the clock edge |
| link_we | input | 1 | Write enable of the link port |
| link_page | input | IW | Page whose successor is written |
| link_next | input | IW | New successor of link_page |
| free_count | output | CW | Number of free pages |
| pool_empty | output | 1 | High while no page is free |

## Verification
The assertions assume that clients only return pages they hold, that every returned chain has a length of at least one and matches its links, and that the free count therefore never exceeds the number of pages. The bench keeps its own record of which pages it holds and builds every returned chain from that record, writing each link through the link port before the release. Under these rules a small pool of eight pages is driven through a drain, releases into the empty and single-page states, round-robin contention and a long pseudo-random mix, with the expected page order kept in a queue.

// File: rtl/page_pool_mgr.sv
module page_pool_mgr #(
  parameter int NUM_PAGES   = 16,
  parameter int NUM_CLIENTS = 4,
  localparam int IW  = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1,
  localparam int CW  = $clog2(NUM_PAGES + 1),
  localparam int CIW = (NUM_CLIENTS > 1) ? $clog2(NUM_CLIENTS) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_CLIENTS-1:0]    alloc_req,
  output logic [NUM_CLIENTS-1:0]    alloc_gnt,
  output logic [IW-1:0]             alloc_page,
  input  logic [NUM_CLIENTS-1:0]    rel_req,
  input  logic [NUM_CLIENTS*IW-1:0] rel_head,
  input  logic [NUM_CLIENTS*IW-1:0] rel_tail,
  input  logic [NUM_CLIENTS*CW-1:0] rel_len,
  output logic [NUM_CLIENTS-1:0]    rel_gnt,
  input  logic                      link_we,
  input  logic [IW-1:0]             link_page,
  input  logic [IW-1:0]             link_next,
  output logic [CW-1:0]             free_count,
  output logic                      pool_empty
);

  logic [IW-1:0]  nxt [NUM_PAGES];
  logic [IW-1:0]  head, tail;
  logic [CW-1:0]  cnt;
  logic [CIW-1:0] a_ptr, r_ptr;

  function automatic logic [NUM_CLIENTS-1:0] rr_pick(input logic [NUM_CLIENTS-1:0] req,
                                                     input logic [CIW-1:0] ptr);
    logic [NUM_CLIENTS-1:0] g;
    g = '0;
    for (int i = NUM_CLIENTS - 1; i >= 0; i--) begin
      int idx;
      idx = (int'(ptr) + i) % NUM_CLIENTS;
      if (req[idx]) begin
        g = '0;
        g[idx] = 1'b1;
      end
    end
    return g;
  endfunction

  function automatic logic [CIW-1:0] enc(input logic [NUM_CLIENTS-1:0] g);
    logic [CIW-1:0] r;
    r = '0;
    for (int i = 0; i < NUM_CLIENTS; i++)
      if (g[i]) r = CIW'(i);
    return r;
  endfunction

  function automatic logic [CIW-1:0] inc(input logic [CIW-1:0] v);
    return CIW'((int'(v) + 1) % NUM_CLIENTS);
  endfunction

  logic          a_any, r_any;
  logic [CIW-1:0] a_idx, r_idx;
  logic [IW-1:0] r_h, r_t;
  logic [CW-1:0] r_n;

  assign free_count = cnt;
  assign pool_empty = (cnt == '0);
  assign alloc_page = head;
  assign alloc_gnt  = rr_pick(pool_empty ? '0 : alloc_req, a_ptr);
  assign rel_gnt    = rr_pick(rel_req, r_ptr);
  assign a_any      = |alloc_gnt;
  assign r_any      = |rel_gnt;
  assign a_idx      = enc(alloc_gnt);
  assign r_idx      = enc(rel_gnt);
  assign r_h        = rel_head[r_idx*IW +: IW];
  assign r_t        = rel_tail[r_idx*IW +: IW];
  assign r_n        = rel_len[r_idx*CW +: CW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_PAGES; i++)
        nxt[i] <= IW'((i + 1) % NUM_PAGES);
      head  <= '0;
      tail  <= IW'(NUM_PAGES - 1);
      cnt   <= CW'(NUM_PAGES);
      a_ptr <= '0;
      r_ptr <= '0;
    end else begin
      if (link_we)
        nxt[link_page] <= link_next;
      if (r_any && !pool_empty)
        nxt[tail] <= r_h;
      cnt <= cnt - CW'(a_any) + (r_any ? r_n : '0);
      if (r_any && (pool_empty || (cnt == CW'(1) && a_any)))
        head <= r_h;
      else if (a_any)
        head <= nxt[head];
      if (r_any)
        tail <= r_t;
      if (a_any) a_ptr <= inc(a_idx);
      if (r_any) r_ptr <= inc(r_idx);
    end
  end

  p_alloc_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(alloc_gnt) && ((alloc_gnt & ~alloc_req) == '0));

  p_rel_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rel_gnt) && ((rel_gnt & ~rel_req) == '0));

  p_count_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> free_count == $past(free_count) - CW'($past(a_any)) + ($past(r_any) ? $past(r_n) : '0));

  p_no_alloc_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pool_empty |-> alloc_gnt == '0);

  p_rel_into_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pool_empty && r_any) |=> alloc_page == $past(r_h));

  p_single_both_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (free_count == CW'(1) && a_any && r_any) |=> alloc_page == $past(r_h) && free_count == $past(r_n));

  p_count_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    free_count <= CW'(NUM_PAGES));

  p_alloc_demand_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!pool_empty && alloc_req != '0) |-> a_any);

endmodule

// File: tb/test_page_pool_mgr.sv
module test_page_pool_mgr;
  localparam int PER = 10;
  localparam int N = 8;
  localparam int C = 4;
  localparam int IW = 3;
  localparam int CW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [C-1:0] alloc_req = '0, rel_req = '0;
  logic [C-1:0] alloc_gnt, rel_gnt;
  logic [IW-1:0] alloc_page;
  logic [C*IW-1:0] rel_head = '0, rel_tail = '0;
  logic [C*CW-1:0] rel_len = '0;
  logic link_we = 1'b0;
  logic [IW-1:0] link_page = '0, link_next = '0;
  logic [CW-1:0] free_count;
  logic pool_empty;

  always #(PER/2) clk = ~clk;

  page_pool_mgr #(.NUM_PAGES(N), .NUM_CLIENTS(C)) i_page_pool_mgr (
    .clk(clk), .rst_n(rst_n), .alloc_req(alloc_req), .alloc_gnt(alloc_gnt),
    .alloc_page(alloc_page), .rel_req(rel_req), .rel_head(rel_head),
    .rel_tail(rel_tail), .rel_len(rel_len), .rel_gnt(rel_gnt),
    .link_we(link_we), .link_page(link_page), .link_next(link_next),
    .free_count(free_count), .pool_empty(pool_empty));

  int errs = 0, checks = 0;
  int q[$];
  int own[$];
  int lst[C][$];
  int ap = 0, rp = 0;
  int last_a, last_r;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int pick(input logic [C-1:0] req, input int ptr);
    for (int i = 0; i < C; i++)
      if (req[(ptr + i) % C]) return (ptr + i) % C;
    return -1;
  endfunction

  task automatic link(input int p, input int n);
    link_we = 1'b1; link_page = IW'(p); link_next = IW'(n);
    @(negedge clk);
    link_we = 1'b0;
  endtask

  // take n held pages (newest first), link them, stage as client c's chain
  task automatic build(input int c, input int n);
    lst[c].delete();
    for (int k = 0; k < n; k++) lst[c].push_back(own.pop_back());
    for (int k = 0; k + 1 < n; k++) link(lst[c][k], lst[c][k+1]);
  endtask

  task automatic cycle(input logic [C-1:0] areq, input logic [C-1:0] rreq);
    int ea, er;
    alloc_req = areq; rel_req = rreq;
    for (int c = 0; c < C; c++) begin
      if (lst[c].size() > 0) begin
        rel_head[c*IW +: IW] = IW'(lst[c][0]);
        rel_tail[c*IW +: IW] = IW'(lst[c][lst[c].size()-1]);
        rel_len[c*CW +: CW]  = CW'(lst[c].size());
      end else begin
        rel_head[c*IW +: IW] = '0; rel_tail[c*IW +: IW] = '0; rel_len[c*CW +: CW] = '0;
      end
    end
    #1;
    ea = (q.size() > 0 && areq != '0) ? pick(areq, ap) : -1;
    er = (rreq != '0) ? pick(rreq, rp) : -1;
    chk(alloc_gnt == ((ea >= 0) ? C'(1 << ea) : '0), "R7 alloc grant", int'(alloc_gnt), (ea >= 0) ? (1 << ea) : 0);
    chk(rel_gnt == ((er >= 0) ? C'(1 << er) : '0), "R8 release grant", int'(rel_gnt), (er >= 0) ? (1 << er) : 0);
    if (ea >= 0) begin
      chk(int'(alloc_page) == q[0], "R2 alloc page", int'(alloc_page), q[0]);
      own.push_back(q.pop_front());
      ap = (ea + 1) % C;
    end
    if (er >= 0) begin
      foreach (lst[er][k]) q.push_back(lst[er][k]);
      lst[er].delete();
      rp = (er + 1) % C;
    end
    last_a = ea; last_r = er;
    @(negedge clk);
    alloc_req = '0; rel_req = '0;
    chk(int'(free_count) == q.size(), "R4 free count", int'(free_count), q.size());
    chk(pool_empty == (q.size() == 0), "R5 empty flag", int'(pool_empty), int'(q.size() == 0));
  endtask

  initial begin
    #(PER * 150000);
    errs++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic [C-1:0] m;
    for (int i = 0; i < N; i++) q.push_back(i);
    #(PER * 2 + 2);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(int'(free_count) == N, "R1 reset count", int'(free_count), N);
    chk(pool_empty == 1'b0, "R1 reset empty", int'(pool_empty), 0);
    chk(alloc_page == '0, "R1 first page", int'(alloc_page), 0);
    // R1 drain in ascending order
    for (int i = 0; i < N; i++) cycle(4'b0001, '0);
    // R5 empty: no grant to anyone
    cycle(4'b1111, '0);
    cycle(4'b0110, '0);
    chk(pool_empty == 1'b1, "R5 empty held", int'(pool_empty), 1);
    // R5 / R3 / R9 release into empty, reverse-linked chain
    build(2, 3);
    cycle('0, 4'b0100);
    for (int i = 0; i < 3; i++) cycle(4'b1000, '0);
    // R6 single page plus simultaneous alloc and release
    build(0, 1);
    cycle('0, 4'b0001);
    build(1, 2);
    cycle(4'b0001, 4'b0010);
    chk(last_a == 0 && last_r == 1, "R6 both granted", last_a * 10 + last_r, 1);
    cycle(4'b0100, '0);
    cycle(4'b0100, '0);
    // R7 rotation under full contention
    build(3, own.size());
    cycle('0, 4'b1000);
    for (int i = 0; i < 6; i++) cycle(4'b1111, '0);
    cycle(4'b1010, '0);
    // R8 rotation with held release requests
    for (int c = 0; c < C; c++) if (own.size() > 0) build(c, 1);
    m = '0;
    for (int c = 0; c < C; c++) if (lst[c].size() > 0) m[c] = 1'b1;
    while (m != '0) begin
      cycle('0, m);
      if (last_r >= 0) m[last_r] = 1'b0;
    end
    // R2 R3 R4 pseudo-random mix
    for (int it = 0; it < 600; it++) begin
      logic [C-1:0] a, r;
      int c, n;
      a = C'($urandom_range(0, 15));
      r = '0;
      if (own.size() > 0 && $urandom_range(0, 2) != 0) begin
        c = $urandom_range(0, C - 1);
        n = $urandom_range(1, (own.size() < 3) ? own.size() : 3);
        build(c, n);
        r[c] = 1'b1;
      end
      cycle(a, r);
      for (int k = 0; k < C; k++) begin
        if (lst[k].size() > 0) begin
          foreach (lst[k][j]) own.push_back(lst[k][j]);
          lst[k].delete();
        end
      end
    end
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule